// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a processor a two-register path into the configuration space of a downstream bus. Software first writes a 32-bit selector word that names a bus, device, function and dword register and sets an enable bit. It then reads or writes a data window with byte, halfword or word accesses. Each data-window access becomes exactly one configuration request on a simple request/completion interface. The register bus is held with ready low until the completion returns.

The data window is little-endian and byte-lane addressable. A byte access at window offset 4+k touches configuration byte k of the selected dword. A halfword access touches bytes 1:0 or 3:2. Read data is shifted down so that the addressed bytes arrive in the low bits. An extended mode takes four more register-number bits from selector bits 27:24, which widens the reachable space to 4 KB per function. A parameter can leave extended mode out at build time.

Top module: `cfg_access_port`

## Requirements
- R1: A word-size write at offset 0 stores all 32 bits of the selector. A read at offsets 0 to 3 returns the whole selector with ready high in the same cycle. Reset clears the selector to zero.
- R2: Byte or halfword writes to offsets 0 to 3 leave the selector unchanged.
- R3: While selector bit 31 is clear, a data-window read (offsets 4 to 7) returns 0xFFFFFFFF at once. A data-window write completes at once. Neither issues a request.
- R4: A request carries bus = selector[23:16], device = selector[15:11], function = selector[10:8], and dword index bits 5:0 = selector[7:2].
- R5: With ext_mode high, dword index bits 9:6 equal selector[27:24]. With ext_mode low, they are zero.
- R6: A byte read (size code 0) at offset 4+k returns completion bits 8k+7:8k in rdata[7:0], with the upper bits zero.
- R7: A halfword read (size code 1) returns completion bytes 1:0 at offset 4 and bytes 3:2 at offset 6, with offset bit 0 ignored. A word read (size code 2) returns the whole completion.
- R8: A write request carries byte enables 0001<<k for a byte at 4+k, 0011 or 1100 for a halfword, and 1111 for a word. The low bytes of bus_wdata appear in the enabled lanes of req_wdata.
- R9: An access with size code 3 issues no request. A read of that size returns 0xFFFFFFFF and a write is dropped.
- R10: An enabled data-window access raises req_valid for exactly one cycle. bus_ready stays low from the access until the cycle after cpl_valid, so the wait grows one cycle per cycle of completion latency.
- R11: A completion with a non-zero status (1 = no device, 2 = unsupported) makes the read return 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Enables extended 4 KB register numbering |
| bus_offs | input | 3 | Byte offset in the block's register space |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_rd | input | 1 | Read strobe, held until bus_ready |
| bus_wr | input | 1 | Write strobe, held until bus_ready |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, low-aligned |
| bus_ready | output | 1 | Access completes on this cycle |
| req_valid | output | 1 | One-cycle configuration request strobe |
| req_write | output | 1 | Request is a write |
| req_bus | output | 8 | Target bus number |
| req_dev | output | 5 | Target device number |
| req_fn | output | 3 | Target function number |
| req_reg | output | 10 | Target dword index |
| req_be | output | 4 | Byte enables of the request |
| req_wdata | output | 32 | Request write data, lane-placed |
| cpl_valid | input | 1 | Completion strobe |
| cpl_status | input | 2 | Completion status, 0 = success |
| cpl_data | input | 32 | Completion read data |

## Verification
The completion is seeded with four distinct bytes, 0x44332211. Every byte and halfword offset therefore yields a different value, so a lane swap or a missing shift shows up directly. Selector words with distinct values in every field, plus a non-zero value in bits 27:24, separate field-slicing faults and show whether extended mode folds the extra bits in. Disabled, reserved-size and error-status accesses are each checked against the request count, so a stray request is caught. Two completion latencies are used so that the stall length can be told apart from a fixed delay.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int WORD_W = 32;
    localparam int BYTES  = WORD_W / 8;
    localparam int LANE_W = $clog2(BYTES);
    localparam int OFFS_W = LANE_W + 1;
    localparam int BUSN_W = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int LOW_W  = 6;
    localparam int EXT_W  = 4;
    localparam int DW_W   = LOW_W + EXT_W;
    localparam int EN_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        CPL_OK    = 2'd0,
        CPL_NODEV = 2'd1,
        CPL_UNSUP = 2'd2,
        CPL_OTHER = 2'd3
    } cpl_stat_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic [BUSN_W-1:0] busn;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [DW_W-1:0]   dw;
    } cfg_target_t;

    typedef struct packed {
        logic              wr;
        logic [BYTES-1:0]  be;
        logic [WORD_W-1:0] wdata;
        logic [LANE_W-1:0] lane;
        acc_size_e         size;
    } cfg_op_t;

    function automatic cfg_target_t decode_sel(input logic [WORD_W-1:0] w, input logic ext);
        cfg_target_t t;
        t.en   = w[EN_BIT];
        t.busn = w[23:16];
        t.dev  = w[15:11];
        t.fn   = w[10:8];
        t.dw   = {(ext ? w[27:24] : {EXT_W{1'b0}}), w[7:2]};
        return t;
    endfunction

    function automatic logic [LANE_W-1:0] lane_base(input acc_size_e sz, input logic [LANE_W-1:0] lane);
        case (sz)
            SZ_BYTE: return lane;
            SZ_HALF: return {lane[LANE_W-1], 1'b0};
            default: return '0;
        endcase
    endfunction

    function automatic logic [BYTES-1:0] lane_be(input acc_size_e sz, input logic [LANE_W-1:0] lane);
        logic [BYTES-1:0] one = {{(BYTES-1){1'b0}}, 1'b1};
        logic [BYTES-1:0] two = {{(BYTES-2){1'b0}}, 2'b11};
        case (sz)
            SZ_BYTE: return one << lane;
            SZ_HALF: return two << lane_base(sz, lane);
            SZ_WORD: return '1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return {{(WORD_W-8){1'b0}}, 8'hFF};
            SZ_HALF: return {{(WORD_W-16){1'b0}}, 16'hFFFF};
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst)     word_q <= '0;
        else if (we) word_q <= wdata;
    end
endmodule

// File: rtl/cfgp_lane_map.sv
module cfgp_lane_map
    import cfgp_pkg::*;
(
    input  acc_size_e         wr_size,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [WORD_W-1:0] wr_data,
    input  acc_size_e         rd_size,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic [WORD_W-1:0] rd_data,
    output logic [BYTES-1:0]  be,
    output logic [WORD_W-1:0] placed,
    output logic [WORD_W-1:0] aligned
);
    logic [WORD_W-1:0] shifted;

    always_comb begin
        be      = lane_be(wr_size, wr_lane);
        placed  = (wr_data & size_mask(wr_size)) << {lane_base(wr_size, wr_lane), 3'b000};
        shifted = rd_data >> {lane_base(rd_size, rd_lane), 3'b000};
        aligned = shifted & size_mask(rd_size);
    end
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              cpl_valid,
    input  logic              cpl_good,
    input  logic [WORD_W-1:0] cpl_aligned,
    output logic              req_valid,
    output logic              idle,
    output logic              done,
    output logic [WORD_W-1:0] rd_hold
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (launch) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (cpl_valid) state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rd_hold <= '1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && cpl_valid)
                rd_hold <= cpl_good ? cpl_aligned : '1;
        end
    end

    assign req_valid = (state_q == ST_ISSUE);
    assign idle      = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfgp_pkg::*;
#(
    parameter bit EXT_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic [OFFS_W-1:0] bus_offs,
    input  logic [1:0]        bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              req_valid,
    output logic              req_write,
    output logic [BUSN_W-1:0] req_bus,
    output logic [DEV_W-1:0]  req_dev,
    output logic [FN_W-1:0]   req_fn,
    output logic [DW_W-1:0]   req_reg,
    output logic [BYTES-1:0]  req_be,
    output logic [WORD_W-1:0] req_wdata,
    input  logic              cpl_valid,
    input  logic [1:0]        cpl_status,
    input  logic [WORD_W-1:0] cpl_data
);
    logic              ext_eff;
    logic [WORD_W-1:0] addr_q;
    logic              addr_we;
    acc_size_e         size;
    logic [LANE_W-1:0] lane;
    logic              data_sel, access, launch;
    logic              idle, done;
    logic [BYTES-1:0]  be_new;
    logic [WORD_W-1:0] wdata_new, cpl_aligned, rd_hold;
    cfg_target_t       tgt;
    cfg_op_t           op_q;

    generate
        if (EXT_SUPPORT) begin : g_ext
            assign ext_eff = ext_mode;
        end else begin : g_conv
            logic unused_ext;
            assign unused_ext = ext_mode;
            assign ext_eff    = 1'b0;
        end
    endgenerate

    always_comb begin
        size     = acc_size_e'(bus_size);
        lane     = bus_offs[LANE_W-1:0];
        data_sel = bus_offs[OFFS_W-1];
        access   = bus_rd | bus_wr;
        tgt      = decode_sel(addr_q, ext_eff);
        addr_we  = idle && bus_wr && !data_sel && (size == SZ_WORD);
        launch   = idle && access && data_sel && tgt.en && (size != SZ_RSVD);
    end

    cfgp_addr_reg u_addr (
        .clk   (clk),
        .rst   (rst),
        .we    (addr_we),
        .wdata (bus_wdata),
        .word_q(addr_q)
    );

    cfgp_lane_map u_lanes (
        .wr_size(size),
        .wr_lane(lane),
        .wr_data(bus_wdata),
        .rd_size(op_q.size),
        .rd_lane(op_q.lane),
        .rd_data(cpl_data),
        .be     (be_new),
        .placed (wdata_new),
        .aligned(cpl_aligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (launch) begin
            op_q.wr    <= bus_wr;
            op_q.be    <= be_new;
            op_q.wdata <= wdata_new;
            op_q.lane  <= lane;
            op_q.size  <= size;
        end
    end

    cfgp_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .cpl_valid  (cpl_valid),
        .cpl_good   (cpl_stat_e'(cpl_status) == CPL_OK),
        .cpl_aligned(cpl_aligned),
        .req_valid  (req_valid),
        .idle       (idle),
        .done       (done),
        .rd_hold    (rd_hold)
    );

    always_comb begin
        bus_ready = done | (idle & access & ~launch);
        if (done)          bus_rdata = rd_hold;
        else if (data_sel) bus_rdata = '1;
        else               bus_rdata = addr_q;
        req_write = op_q.wr;
        req_be    = op_q.be;
        req_wdata = op_q.wdata;
        req_bus   = tgt.busn;
        req_dev   = tgt.dev;
        req_fn    = tgt.fn;
        req_reg   = tgt.dw;
    end
endmodule

// File: rtl/cfg_access_port_chk.sv
module cfg_access_port_chk
    import cfgp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ext_mode,
    input logic              bus_wr,
    input logic              bus_ready,
    input logic              req_valid,
    input logic [DW_W-1:0]   req_reg,
    input logic [BYTES-1:0]  req_be,
    input logic [WORD_W-1:0] addr_q
);
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> addr_q[EN_BIT]); // R3
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid); // R10
    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !bus_ready); // R10
    AST_CONV_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ext_mode) |-> (req_reg[DW_W-1:LOW_W] == '0)); // R5
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones(req_be) == 1 || req_be == 4'b0011 ||
                       req_be == 4'b1100 || req_be == 4'b1111)); // R8
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(addr_q)); // R1
endmodule

bind cfg_access_port cfg_access_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_mode (ext_mode),
    .bus_wr   (bus_wr),
    .bus_ready(bus_ready),
    .req_valid(req_valid),
    .req_reg  (req_reg),
    .req_be   (req_be),
    .addr_q   (addr_q)
);

// File: tb/test_cfg_access_port.sv
module test_cfg_access_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_mode = 1'b0;
    logic [2:0]  bus_offs = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        req_valid, req_write;
    logic [7:0]  req_bus;
    logic [4:0]  req_dev;
    logic [2:0]  req_fn;
    logic [9:0]  req_reg;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // downstream model state
    int          m_lat = 1;
    logic [31:0] m_data = 32'h44332211;
    logic [1:0]  m_status = 2'd0;
    int          m_cnt = 0;
    logic        l_write;
    logic [7:0]  l_bus;
    logic [4:0]  l_dev;
    logic [2:0]  l_fn;
    logic [9:0]  l_reg;
    logic [3:0]  l_be;
    logic [31:0] l_wdata;

    always #5 clk = ~clk;

    cfg_access_port i_cfg_access_port (
        .clk(clk), .rst(rst), .ext_mode(ext_mode),
        .bus_offs(bus_offs), .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg), .req_be(req_be),
        .req_wdata(req_wdata), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .cpl_data(cpl_data)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                m_cnt++;
                l_write = req_write; l_bus = req_bus; l_dev = req_dev;
                l_fn = req_fn; l_reg = req_reg; l_be = req_be; l_wdata = req_wdata;
                repeat (m_lat) @(negedge clk);
                cpl_valid = 1'b1; cpl_data = m_data; cpl_status = m_status;
                @(negedge clk);
                cpl_valid = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [2:0] offs, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_wr = wr; bus_rd = !wr; bus_offs = offs; bus_size = sz; bus_wdata = wd;
        waits = 0;
        forever begin
            #4;
            if (bus_ready) begin
                rd = bus_rdata;
                @(posedge clk);
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic set_sel(input logic [31:0] w);
        logic [31:0] d; int wt;
        access(1, 3'd0, 2'd2, w, d, wt);
    endtask

    task automatic t_reset;
        logic [31:0] d; int wt;
        access(0, 3'd0, 2'd2, 0, d, wt);
        check("R1 reset selector", d, 32'h0);
        check("R1 selector read no stall", wt, 0);
    endtask

    task automatic t_sel_reg;
        logic [31:0] d; int wt;
        set_sel(32'h7BCD_EF13);
        access(0, 3'd2, 2'd0, 0, d, wt);
        check("R1 selector readback", d, 32'h7BCD_EF13);
        access(1, 3'd0, 2'd0, 32'hFFFF_FFFF, d, wt);
        access(1, 3'd2, 2'd1, 32'h0000_0000, d, wt);
        access(0, 3'd0, 2'd2, 0, d, wt);
        check("R2 narrow selector writes ignored", d, 32'h7BCD_EF13);
    endtask

    task automatic t_disabled;
        logic [31:0] d; int wt, c0;
        c0 = m_cnt;
        set_sel(32'h00A5_9B00);
        access(0, 3'd4, 2'd2, 0, d, wt);
        check("R3 disabled read data", d, 32'hFFFF_FFFF);
        check("R3 disabled read no stall", wt, 0);
        access(1, 3'd4, 2'd2, 32'h1234_5678, d, wt);
        repeat (4) @(negedge clk);
        check("R3 no request while disabled", m_cnt - c0, 0);
    endtask

    task automatic t_fields;
        logic [31:0] d; int wt;
        ext_mode = 1'b0;
        set_sel({1'b1, 3'b0, 4'hC, 8'hA5, 5'h13, 3'h5, 6'h2D, 2'b00});
        access(0, 3'd4, 2'd2, 0, d, wt);
        check("R4 bus field", l_bus, 32'hA5);
        check("R4 device field", l_dev, 32'h13);
        check("R4 function field", l_fn, 32'h5);
        check("R5 conventional register index", l_reg, {22'h0, 4'h0, 6'h2D});
        ext_mode = 1'b1;
        access(0, 3'd4, 2'd2, 0, d, wt);
        check("R5 extended register index", l_reg, {22'h0, 4'hC, 6'h2D});
        ext_mode = 1'b0;
    endtask

    task automatic t_byte_reads;
        logic [31:0] d; int wt;
        m_data = 32'h4433_2211;
        set_sel(32'h8001_0804);
        for (int k = 0; k < 4; k++) begin
            access(0, 3'(4 + k), 2'd0, 0, d, wt);
            check($sformatf("R6 byte lane %0d", k), d, 32'(8'h11 * (k + 1)));
        end
    endtask

    task automatic t_wide_reads;
        logic [31:0] d; int wt;
        m_data = 32'h4433_2211;
        access(0, 3'd4, 2'd1, 0, d, wt);
        check("R7 half low", d, 32'h0000_2211);
        access(0, 3'd7, 2'd1, 0, d, wt);
        check("R7 half high bit0 ignored", d, 32'h0000_4433);
        access(0, 3'd4, 2'd2, 0, d, wt);
        check("R7 word read", d, 32'h4433_2211);
    endtask

    task automatic t_writes;
        logic [31:0] d; int wt;
        access(1, 3'd6, 2'd0, 32'h0000_00AB, d, wt);
        check("R8 byte write flag", l_write, 1);
        check("R8 byte write enables", l_be, 4'b0100);
        check("R8 byte write lane data", l_wdata & 32'h00FF_0000, 32'h00AB_0000);
        access(1, 3'd6, 2'd1, 32'h0000_BEEF, d, wt);
        check("R8 half write enables", l_be, 4'b1100);
        check("R8 half write lane data", l_wdata & 32'hFFFF_0000, 32'hBEEF_0000);
        access(1, 3'd4, 2'd2, 32'hCAFE_F00D, d, wt);
        check("R8 word write", {l_be, 28'h0} | (l_wdata >> 4), {4'hF, 28'hCAFEF00} );
    endtask

    task automatic t_bad_size;
        logic [31:0] d; int wt, c0;
        c0 = m_cnt;
        access(0, 3'd4, 2'd3, 0, d, wt);
        check("R9 reserved size read", d, 32'hFFFF_FFFF);
        access(1, 3'd4, 2'd3, 32'h1, d, wt);
        repeat (4) @(negedge clk);
        check("R9 reserved size no request", m_cnt - c0, 0);
    endtask

    task automatic t_stall;
        logic [31:0] d; int wt, c0;
        m_lat = 1; c0 = m_cnt;
        access(0, 3'd4, 2'd2, 0, d, wt);
        check("R10 stall latency 1", wt, 3);
        m_lat = 5;
        access(0, 3'd4, 2'd2, 0, d, wt);
        check("R10 stall latency 5", wt, 7);
        check("R10 one request per access", m_cnt - c0, 2);
        m_lat = 1;
    endtask

    task automatic t_error;
        logic [31:0] d; int wt;
        m_status = 2'd1;
        access(0, 3'd5, 2'd0, 0, d, wt);
        check("R11 no-device read", d, 32'hFFFF_FFFF);
        m_status = 2'd2;
        access(0, 3'd4, 2'd2, 0, d, wt);
        check("R11 unsupported read", d, 32'hFFFF_FFFF);
        m_status = 2'd0;
        access(0, 3'd4, 2'd0, 0, d, wt);
        check("R11 recovery after error", d, 32'h0000_0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sel_reg();
        t_disabled();
        t_fields();
        t_byte_reads();
        t_wide_reads();
        t_writes();
        t_bad_size();
        t_stall();
        t_error();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule